// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Engine

This block multiplies a stream of signed 8-bit input vectors by a small weight matrix that stays resident inside a grid of processing cells. The default grid has two rows and two columns. Every cell holds one weight and multiplies the activation passing through it with a radix-4 Booth multiplier. It adds that product to the partial sum coming down from the cell above and clamps the total to the signed 8-bit range before handing it on. Activations move left to right along each row. Partial sums move top to bottom along each column. The bottom of each column delivers one element of the result.

Weights are loaded first through a byte-wide port: a begin strobe, then one byte per cell. A start strobe then opens a run. The host streams one input vector per accepted beat, each vector holding one byte per grid row. The engine skews the rows internally, so the host presents each vector whole. When the last result element lands, a one-cycle done pulse fires. The results stay in place until the next run and are read back through an addressed, combinational read port. A flat debug bus shows each cell's weight, latest product and clamped sum.

Top module: `sysmat_engine`

## Requirements
- R1: After reset, busy and done are low, every result address reads 0 and the whole debug bus reads 0.
- R2: A wt_begin strobe followed by four wt_valid bytes writes the cells in row-major order: byte k goes to the cell at row k/2, column k%2. Cell k owns debug bits [32k+31:32k]: the weight sits in the low 8 bits, the latest product in bits 8 to 23 and the clamped sum in bits 24 to 31. busy is high from the cycle after wt_begin until the fourth byte is taken.
- R3: start begins a run only when the engine is idle and a complete weight load has finished. A start before any load, or during a load, leaves busy low once the load ends, and no done follows.
- R4: wt_valid outside a load leaves every stored weight unchanged.
- R5: After start, two accepted act_valid beats carry input rows 0 and 1. Bits [7:0] of act_data feed grid row 0 and bits [15:8] feed grid row 1. Result (i,c) is read at rd_row=i, rd_col=c and equals clamp(clamp(x[i][0]*w[0][c]) + x[i][1]*w[1][c]).
- R6: Every cell clamps its sum to -128..127, so the value leaving the top row is already clamped before the bottom row adds to it. Both the upper and the lower limit apply.
- R7: done is a single-cycle pulse that rises 4 clock cycles after the edge that accepts the last beat of a run. busy is low while done is high.
- R8: act_valid outside a run has no effect: the stored results do not change.
- R9: Each product is exact over the full operand range, including -128 * -128 = 16384, as seen in each cell's debug product field.
- R10: Idle cycles between the beats of a run change neither the results nor the done latency, which is counted from the last beat.
- R11: Weights stay resident: a second run without a reload uses the same weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wt_begin | input | 1 | Opens a weight load while the engine is idle |
| wt_valid | input | 1 | Weight byte strobe |
| wt_data | input | 8 | Signed weight byte |
| start | input | 1 | Opens a run when idle with weights loaded |
| act_valid | input | 1 | Activation beat strobe |
| act_data | input | 16 | One signed byte per grid row, row 0 in the low byte |
| busy | output | 1 | High while loading, running or draining |
| done | output | 1 | One-cycle pulse when all results are stored |
| rd_row | input | 1 | Result row address (input vector index) |
| rd_col | input | 1 | Result column address |
| rd_data | output | 8 | Addressed signed result |
| dbg_bus | output | 128 | Per-cell weight, product and clamped sum, 32 bits per cell |

## Verification
The bench builds the engine with its default parameters: 8-bit data, two rows, two columns and two input vectors per run. At these values every extreme operand pairing can be reached directly, including the lone product that needs 16 bits. Both clamp limits can be driven at the top-row cell and again at the bottom-row cell. The short four-cycle pipeline also makes it simple to count the done latency, with and without gaps between beats.

// File: rtl/sysmat_pkg.sv
`timescale 1ns/1ps
package sysmat_pkg;

  // Controller phases shared by the controller, top and checker.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } sm_state_e;

endpackage

// File: rtl/sysmat_booth_mul.sv
`timescale 1ns/1ps
// Signed W x W multiplier: radix-4 Booth digits, partial products merged
// in carry-save form, one carry-propagate add at the end.
module sysmat_booth_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int PW  = 2 * W;
  localparam int NPP = W / 2;

  logic [W:0]    b_ext;
  logic [PW-1:0] a_ext;
  logic [PW-1:0] pp [NPP];

  assign b_ext = {b, 1'b0};
  assign a_ext = {{W{a[W-1]}}, a};

  // One partial product per Booth digit
  for (genvar i = 0; i < NPP; i++) begin : g_pp
    logic [2:0]    dig;
    logic [PW-1:0] mag;
    assign dig = b_ext[2*i+2 -: 3];
    always_comb begin
      case (dig)
        3'b001, 3'b010: mag = a_ext;
        3'b011:         mag = a_ext << 1;
        3'b100:         mag = -(a_ext << 1);
        3'b101, 3'b110: mag = -a_ext;
        default:        mag = '0;
      endcase
    end
    assign pp[i] = mag << (2 * i);
  end

  // Carry-save merge of the partial products
  always_comb begin : b_csa
    logic [PW-1:0] acc_s;
    logic [PW-1:0] acc_c;
    logic [PW-1:0] t_s;
    logic [PW-1:0] t_c;
    acc_s = pp[0];
    acc_c = '0;
    for (int i = 1; i < NPP; i++) begin
      t_s   = acc_s ^ acc_c ^ pp[i];
      t_c   = ((acc_s & acc_c) | (acc_s & pp[i]) | (acc_c & pp[i])) << 1;
      acc_s = t_s;
      acc_c = t_c;
    end
    p = acc_s + acc_c;
  end

endmodule

// File: rtl/sysmat_pe.sv
`timescale 1ns/1ps
// One grid cell: resident weight, Booth product, add to incoming sum,
// clamp to DW signed bits.
module sysmat_pe #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            w_we,
  input  logic [DW-1:0]   w_din,
  input  logic [DW-1:0]   a_in,
  input  logic [DW-1:0]   s_in,
  output logic [DW-1:0]   s_out,
  output logic [2*DW-1:0] p_out,
  output logic [DW-1:0]   w_out
);
  localparam int PW     = 2 * DW;
  localparam int IW     = PW + 1;
  localparam int SMAX_I = (1 << (DW - 1)) - 1;
  localparam logic signed [IW-1:0] SMAX = IW'(SMAX_I);
  localparam logic signed [IW-1:0] SMIN = IW'(-SMAX_I - 1);

  logic [DW-1:0]        w_q, w_n;
  logic [DW-1:0]        s_q, s_n;
  logic [PW-1:0]        p_q, p_n;
  logic [PW-1:0]        prod;
  logic signed [IW-1:0] sum_wide;

  sysmat_booth_mul #(.W(DW)) u_mul (
    .a (a_in),
    .b (w_q),
    .p (prod)
  );

  assign sum_wide = $signed({{(IW-DW){s_in[DW-1]}}, s_in})
                  + $signed({prod[PW-1], prod});

  always_comb begin
    w_n = w_we ? w_din : w_q;
    p_n = en ? prod : p_q;
    s_n = s_q;
    if (en) begin
      if (sum_wide > SMAX)      s_n = SMAX[DW-1:0];
      else if (sum_wide < SMIN) s_n = SMIN[DW-1:0];
      else                      s_n = sum_wide[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q <= '0;
      s_q <= '0;
      p_q <= '0;
    end else begin
      w_q <= w_n;
      s_q <= s_n;
      p_q <= p_n;
    end
  end

  assign s_out = s_q;
  assign p_out = p_q;
  assign w_out = w_q;

endmodule

// File: rtl/sysmat_ctrl.sv
`timescale 1ns/1ps
// Sequencer: weight-load counter, run acceptance, result tag pipeline, done.
module sysmat_ctrl
  import sysmat_pkg::*;
#(
  parameter int CELLS = 4,
  parameter int NVEC  = 2,
  parameter int LAT   = 4,
  parameter int VW    = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wt_begin,
  input  logic                    wt_valid,
  input  logic                    start,
  input  logic                    act_valid,
  output logic [CELLS-1:0]        wt_we,
  output logic                    accept,
  output logic [LAT-1:0]          tag_vld,
  output logic [LAT-1:0][VW-1:0]  tag_idx,
  output logic                    busy,
  output logic                    done,
  output sm_state_e               st
);
  localparam int LW = (CELLS > 1) ? $clog2(CELLS) : 1;

  sm_state_e             st_q, st_n;
  logic [LW-1:0]         ld_q, ld_n;
  logic [VW-1:0]         vc_q, vc_n;
  logic                  loaded_q, loaded_n;
  logic                  done_q, done_n;
  logic [LAT-1:0]        tv_q, tv_n;
  logic [LAT-1:0][VW-1:0] ti_q, ti_n;
  logic                  last_out;
  logic                  tag_en;

  assign last_out = tv_q[LAT-1] && (ti_q[LAT-1] == VW'(NVEC - 1));

  always_comb begin
    st_n     = st_q;
    ld_n     = ld_q;
    vc_n     = vc_q;
    loaded_n = loaded_q;
    accept   = 1'b0;
    wt_we    = '0;
    done_n   = last_out;
    case (st_q)
      ST_IDLE: begin
        if (wt_begin) begin
          st_n     = ST_LOAD;
          ld_n     = '0;
          loaded_n = 1'b0;
        end else if (start && loaded_q) begin
          st_n = ST_RUN;
          vc_n = '0;
        end
      end
      ST_LOAD: begin
        if (wt_valid) begin
          wt_we[ld_q] = 1'b1;
          if (ld_q == LW'(CELLS - 1)) begin
            st_n     = ST_IDLE;
            loaded_n = 1'b1;
          end else begin
            ld_n = ld_q + 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (act_valid) begin
          accept = 1'b1;
          if (vc_q == VW'(NVEC - 1)) st_n = ST_DRAIN;
          else                       vc_n = vc_q + 1'b1;
        end
      end
      ST_DRAIN: begin
        if (last_out) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // Tag pipeline follows each accepted beat down the array
  assign tag_en = accept | (|tv_q);

  always_comb begin
    tv_n = tv_q;
    ti_n = ti_q;
    if (tag_en) begin
      tv_n    = {tv_q[LAT-2:0], accept};
      ti_n[0] = vc_q;
      for (int k = 1; k < LAT; k++) ti_n[k] = ti_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ld_q     <= '0;
      vc_q     <= '0;
      loaded_q <= 1'b0;
      done_q   <= 1'b0;
      tv_q     <= '0;
      ti_q     <= '0;
    end else begin
      st_q     <= st_n;
      ld_q     <= ld_n;
      vc_q     <= vc_n;
      loaded_q <= loaded_n;
      done_q   <= done_n;
      tv_q     <= tv_n;
      ti_q     <= ti_n;
    end
  end

  assign tag_vld = tv_q;
  assign tag_idx = ti_q;
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign st      = st_q;

endmodule

// File: rtl/sysmat_engine.sv
`timescale 1ns/1ps
module sysmat_engine
  import sysmat_pkg::*;
#(
  parameter int DW   = 8,
  parameter int ROWS = 2,
  parameter int COLS = 2,
  parameter int NVEC = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wt_begin,
  input  logic                       wt_valid,
  input  logic [DW-1:0]              wt_data,
  input  logic                       start,
  input  logic                       act_valid,
  input  logic [ROWS*DW-1:0]         act_data,
  output logic                       busy,
  output logic                       done,
  input  logic [((NVEC > 1) ? $clog2(NVEC) : 1)-1:0] rd_row,
  input  logic [((COLS > 1) ? $clog2(COLS) : 1)-1:0] rd_col,
  output logic [DW-1:0]              rd_data,
  output logic [ROWS*COLS*4*DW-1:0]  dbg_bus
);
  localparam int CELLS = ROWS * COLS;
  localparam int LAT   = ROWS + COLS;
  localparam int VW    = (NVEC > 1) ? $clog2(NVEC) : 1;
  localparam int PW    = 2 * DW;
  localparam int DBW   = 4 * DW;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // Sequencer
  logic [CELLS-1:0]       wt_we;
  logic                   accept;
  logic [LAT-1:0]         tag_vld;
  logic [LAT-1:0][VW-1:0] tag_idx;
  sm_state_e              st;
  logic                   adv;

  sysmat_ctrl #(
    .CELLS (CELLS),
    .NVEC  (NVEC),
    .LAT   (LAT),
    .VW    (VW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wt_begin  (wt_begin),
    .wt_valid  (wt_valid),
    .start     (start),
    .act_valid (act_valid),
    .wt_we     (wt_we),
    .accept    (accept),
    .tag_vld   (tag_vld),
    .tag_idx   (tag_idx),
    .busy      (busy),
    .done      (done),
    .st        (st)
  );

  // Array clock enable: advance while a beat enters or any is in flight
  assign adv = accept | (|tag_vld);

  // Input register, one lane per grid row
  logic [DW-1:0] act_q [ROWS];
  logic [DW-1:0] act_n [ROWS];

  always_comb begin
    for (int k = 0; k < ROWS; k++)
      act_n[k] = accept ? act_data[k*DW +: DW] : act_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < ROWS; k++) act_q[k] <= '0;
    end else if (!rst_core_n) begin
      for (int k = 0; k < ROWS; k++) act_q[k] <= '0;
    end else begin
      for (int k = 0; k < ROWS; k++) act_q[k] <= act_n[k];
    end
  end

  // Row skew: grid row r sees its lane r cycles later
  logic [DW-1:0] row_in [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_skew
    if (r == 0) begin : g_direct
      assign row_in[r] = act_q[r];
    end else begin : g_delay
      logic [DW-1:0] dly_q [r];
      always_ff @(posedge clk or negedge rst_core_n) begin
        if (!rst_core_n) begin
          for (int k = 0; k < r; k++) dly_q[k] <= '0;
        end else if (adv) begin
          dly_q[0] <= act_q[r];
          for (int k = 1; k < r; k++) dly_q[k] <= dly_q[k-1];
        end
      end
      assign row_in[r] = dly_q[r-1];
    end
  end

  // Grid interconnect
  logic [DW-1:0] a_link [ROWS][COLS];
  logic [DW-1:0] a_reg  [ROWS][COLS];
  logic [DW-1:0] s_link [ROWS+1][COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_arow
    for (genvar c = 0; c < COLS; c++) begin : g_acol
      if (c == 0) begin : g_edge
        assign a_link[r][c] = row_in[r];
      end else begin : g_pass
        assign a_link[r][c] = a_reg[r][c-1];
      end
      always_ff @(posedge clk or negedge rst_core_n) begin
        if (!rst_core_n) a_reg[r][c] <= '0;
        else if (adv)    a_reg[r][c] <= a_link[r][c];
      end
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_top
    assign s_link[0][c] = '0;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      logic [PW-1:0] p_w;
      logic [DW-1:0] w_w;

      sysmat_pe #(.DW(DW)) u_pe (
        .clk   (clk),
        .rst_n (rst_core_n),
        .en    (adv),
        .w_we  (wt_we[IDX]),
        .w_din (wt_data),
        .a_in  (a_link[r][c]),
        .s_in  (s_link[r][c]),
        .s_out (s_link[r+1][c]),
        .p_out (p_w),
        .w_out (w_w)
      );

      assign dbg_bus[IDX*DBW +: DBW] = {s_link[r+1][c], p_w, w_w};
    end
  end

  // Result store: column c's bottom is valid when its tag reaches ROWS+c
  logic [DW-1:0] res_q [NVEC][COLS];
  logic [DW-1:0] res_n [NVEC][COLS];

  always_comb begin
    res_n = res_q;
    for (int c = 0; c < COLS; c++) begin
      if (tag_vld[ROWS+c]) begin
        for (int v = 0; v < NVEC; v++) begin
          if (tag_idx[ROWS+c] == VW'(v)) res_n[v][c] = s_link[ROWS][c];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      for (int v = 0; v < NVEC; v++)
        for (int c = 0; c < COLS; c++) res_q[v][c] <= '0;
    end else begin
      res_q <= res_n;
    end
  end

  assign rd_data = res_q[rd_row][rd_col];

endmodule

// File: rtl/sysmat_engine_chk.sv
`timescale 1ns/1ps
module sysmat_engine_chk
  import sysmat_pkg::*;
#(
  parameter int DW    = 8,
  parameter int COLS  = 2,
  parameter int CELLS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    busy,
  input logic                    done,
  input sm_state_e               st,
  input logic [CELLS*4*DW-1:0]   dbg
);
  localparam int DBW    = 4 * DW;
  localparam int PW     = 2 * DW;
  localparam int SMAX_I = (1 << (DW - 1)) - 1;

  logic [CELLS*DW-1:0] wts;
  for (genvar i = 0; i < CELLS; i++) begin : g_w
    assign wts[i*DW +: DW] = dbg[i*DBW +: DW];
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_load_never_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOAD) |=> (st != ST_RUN));

  assert_weights_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_LOAD) |=> $stable(wts));

  for (genvar c = 0; c < COLS; c++) begin : g_clamp
    logic signed [PW-1:0] prod_c;
    logic signed [DW-1:0] sum_c;
    assign prod_c = $signed(dbg[c*DBW + DW +: PW]);
    assign sum_c  = $signed(dbg[c*DBW + 3*DW +: DW]);

    assert_top_clamp_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (prod_c > $signed(PW'(SMAX_I))) |-> (sum_c == $signed(DW'(SMAX_I))));

    assert_top_clamp_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (prod_c < $signed(PW'(-SMAX_I - 1))) |-> (sum_c == $signed(DW'(-SMAX_I - 1))));
  end

endmodule

bind sysmat_engine sysmat_engine_chk #(
  .DW    (DW),
  .COLS  (COLS),
  .CELLS (CELLS)
) u_chk (
  .clk   (clk),
  .rst_n (rst_core_n),
  .busy  (busy),
  .done  (done),
  .st    (st),
  .dbg   (dbg_bus)
);

// File: tb/sysmat_engine_tb.sv
`timescale 1ns/1ps
module sysmat_engine_tb;

  logic         clk;
  logic         rst_n;
  logic         wt_begin, wt_valid, start, act_valid;
  logic [7:0]   wt_data;
  logic [15:0]  act_data;
  logic         busy, done;
  logic [0:0]   rd_row, rd_col;
  logic [7:0]   rd_data;
  logic [127:0] dbg_bus;

  sysmat_engine u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wt_begin  (wt_begin),
    .wt_valid  (wt_valid),
    .wt_data   (wt_data),
    .start     (start),
    .act_valid (act_valid),
    .act_data  (act_data),
    .busy      (busy),
    .done      (done),
    .rd_row    (rd_row),
    .rd_col    (rd_col),
    .rd_data   (rd_data),
    .dbg_bus   (dbg_bus)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  int checks = 0;
  int errors = 0;
  int runs_seen = 0;
  bit finished = 0;

  // Scoreboard queues
  int    q_val[$];
  string q_tag[$];
  int    q_done[$];

  int cur_w [4];
  int last_exp [4];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat8(input int v);
    if (v > 127)  return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int dbg_w(input int idx);
    return int'($signed(dbg_bus[idx*32 +: 8]));
  endfunction
  function automatic int dbg_p(input int idx);
    return int'($signed(dbg_bus[idx*32+8 +: 16]));
  endfunction
  function automatic int dbg_s(input int idx);
    return int'($signed(dbg_bus[idx*32+24 +: 8]));
  endfunction

  task automatic read_res(output int v [4]);
    for (int i = 0; i < 2; i++) begin
      for (int j = 0; j < 2; j++) begin
        rd_row = 1'(i);
        rd_col = 1'(j);
        #0.5;
        v[i*2+j] = int'($signed(rd_data));
      end
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor: pops expected items whenever a done pulse is seen
  initial begin
    int got [4];
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (q_done.size() == 0) begin
          chk("R3 unexpected done", 1, 0);
        end else begin
          chk("R7 done latency", cyc, q_done.pop_front());
          read_res(got);
          for (int k = 0; k < 4; k++) begin
            if (q_val.size() == 0) chk("scoreboard empty", 1, 0);
            else chk(q_tag.pop_front(), got[k], q_val.pop_front());
          end
        end
        runs_seen++;
      end
    end
  end

  task automatic load_w(input int w [4], input bit start_mid);
    @(negedge clk);
    wt_begin = 1'b1;
    @(negedge clk);
    wt_begin = 1'b0;
    for (int i = 0; i < 4; i++) begin
      wt_valid = 1'b1;
      wt_data  = 8'(w[i]);
      start    = start_mid && (i == 1);
      @(negedge clk);
      if (i == 1) chk("R2 busy during load", int'(busy), 1);
      cur_w[i] = w[i];
    end
    wt_valid = 1'b0;
    start    = 1'b0;
    chk("R2 busy low after fourth byte", int'(busy), 0);
    for (int i = 0; i < 4; i++) chk("R2 row-major weight slot", dbg_w(i), w[i]);
  endtask

  task automatic run_mat(input int x [2][2], input int gap, input string tag);
    int n0 = runs_seen;
    for (int i = 0; i < 2; i++) begin
      for (int c = 0; c < 2; c++) begin
        last_exp[i*2+c] = sat8(sat8(x[i][0] * cur_w[c]) + x[i][1] * cur_w[2+c]);
        q_val.push_back(last_exp[i*2+c]);
        q_tag.push_back(tag);
      end
    end
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 2; i++) begin
      act_valid = 1'b1;
      act_data  = {8'(x[i][1]), 8'(x[i][0])};
      if (i == 1) q_done.push_back(cyc + 5);
      @(negedge clk);
      act_valid = 1'b0;
      if (i == 0) repeat (gap) @(negedge clk);
    end
    wait (runs_seen == n0 + 1);
    @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    int got [4];
    rst_n = 1'b0; wt_begin = 0; wt_valid = 0; wt_data = 0;
    start = 0; act_valid = 0; act_data = 0; rd_row = 0; rd_col = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 debug bus zero", int'(dbg_bus == '0), 1);
    read_res(got);
    for (int k = 0; k < 4; k++) chk("R1 result zero", got[k], 0);

    // R3 start with no weights
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R3 start before load", int'(busy), 0);
    @(negedge clk);
    chk("R3 start before load later", int'(busy), 0);

    // R2 load with a start in the middle (R3)
    load_w('{3, -2, 5, 7}, 1'b1);
    repeat (3) @(negedge clk);
    chk("R3 start during load ignored", int'(busy), 0);

    // R4 stray weight strobe while idle
    wt_valid = 1'b1; wt_data = 8'd99;
    @(negedge clk);
    wt_valid = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) chk("R4 weight unchanged", dbg_w(i), cur_w[i]);

    // R5 / R7 basic run
    run_mat('{'{1, 2}, '{-3, 4}}, 0, "R5 product");

    // R8 activation beats while idle
    act_valid = 1'b1; act_data = 16'h7F7F;
    repeat (2) @(negedge clk);
    act_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 busy stays low", int'(busy), 0);
    read_res(got);
    for (int k = 0; k < 4; k++) chk("R8 results unchanged", got[k], last_exp[k]);

    // R10 gapped beats, R11 same weights without reload
    run_mat('{'{-6, 9}, '{11, -12}}, 3, "R10 gapped run");
    run_mat('{'{20, -20}, '{0, 15}}, 0, "R11 resident weights");

    // R6 saturation: intermediate clamp and final clamp at both limits
    load_w('{100, -100, 127, -128}, 1'b0);
    run_mat('{'{100, -1}, '{-128, 1}}, 0, "R6 intermediate clamp");
    run_mat('{'{1, 127}, '{-1, -128}}, 1, "R6 final clamp");

    // R9 extreme products seen on the debug bus
    load_w('{-128, 127, -128, -1}, 1'b0);
    run_mat('{'{127, -128}, '{-128, -128}}, 0, "R9 extreme operands");
    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < 2; c++) begin
        chk("R9 exact product", dbg_p(r*2+c), -128 * cur_w[r*2+c]);
      end
    end
    chk("R9 full-range product 16384", dbg_p(0), 16384);
    chk("R6 top-row clamp of product", dbg_s(0), 127);
    chk("R6 top-row clamp low", dbg_s(1), -128);

    repeat (3) @(negedge clk);
    chk("R7 no stray done", q_done.size(), 0);
    finish_sim();
  end

endmodule